// File: doc/BRIEF.md
# BCD Calendar Timekeeper with Snapshot

This block keeps wall-clock time and date in packed BCD. It holds seconds, minutes, hours, day of month, month, two-digit year (taken as the 2000s) and a weekday counter. While counting is enabled, each pulse on the one-hertz tick input advances the time by one second, and the carries ripple through to the calendar fields. Month lengths and the February leap day are handled in the block.

Software reaches the block through a byte-wide register port that has an address, a write strobe, write data and combinational read data. To set the clock, software halts counting, loads the fields, and then restarts counting. A capture command copies the live fields into a shadow set. Later reads then return one coherent instant, even though the live fields keep running between the individual byte reads. A mode bit presents the hour field in 12-hour form, with a PM flag.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the fields read second 0x00, minute 0x00, hour 0x00, day 0x01, month 0x01, year 0x00 and weekday 0x00. The control register at 0x08 and the status register at 0x09 both read 0x00.
- R2: Addresses 0x00 to 0x06 hold, in order, seconds, minutes, hours, day, month, year and weekday. On a counted tick, seconds roll from 0x59 to 0x00 and carry into minutes. Minutes roll from 0x59 to 0x00 and carry into hours. Hours roll from 0x23 to 0x00 and carry into the day.
- R3: On a day carry, the day returns to 0x01 once it has reached the month length. That length is 0x30 for months 0x04, 0x06, 0x09 and 0x11, and 0x31 for the other months except February. February has 0x29 days when the year value is divisible by 4 and 0x28 days otherwise.
- R4: On a month carry, month 0x12 rolls to 0x01 and the year increments. Year 0x99 wraps to 0x00.
- R5: The weekday counts 0 to 6, wraps from 6 to 0, and advances on every day carry.
- R6: A tick is counted only when control bit 0 was already 1 before the clock edge. A tick that arrives while the clock is halted, or in the same cycle as the write that sets bit 0, has no effect. Status bit 1 (value 0x02) reads 1 while counting is enabled.
- R7: A write to addresses 0x00 to 0x06 while bit 0 is 0 takes effect at the next clock edge. The same write while bit 0 is 1 is ignored.
- R8: Writing the control register with bit 6 set copies all seven live fields into a shadow set. Reads of 0x00 to 0x06 then return the shadow values until a control write with bit 6 clear.
- R9: Control bit 6 reads 1 for exactly one cycle after the capture write and then clears itself. Bits 0 and 3 read back as written.
- R10: With control bit 3 set, the hour field reads as BCD 0x01 to 0x12 with bit 7 as the PM flag: hour 00 reads 0x12, hour 12 reads 0x92 and hour 15 reads 0x83. Hour writes in that mode are taken in the same form, and the count continues in 24-hour form.
- R11: Reads of addresses other than 0x00 to 0x06, 0x08 and 0x09 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| bus_addr | input | AW | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, same cycle |

## Verification
Read data is combinational, so the bench samples it 1 ns after it drives the address on a falling edge. A write or tick presented on a falling edge lands on the rising edge that follows. Every read that checks it therefore comes at least one full cycle later. For the capture flag, the bench samples control once right after the capture edge and expects bit 6 set. It samples once more a cycle later and expects the bit clear. The bench drives the run-enabling write and a tick in the same cycle and expects the seconds to stay unchanged.

// File: rtl/bcd_rtc.sv
module bcd_rtc #(
  parameter int AW = 5,
  parameter logic [AW-1:0] CTRL_ADDR = AW'(8),
  parameter logic [AW-1:0] STAT_ADDR = AW'(9)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_1hz,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata
);
  localparam logic [AW-1:0] NFIELD = AW'(7);

  logic [7:0] sec_r, min_r, hr_r, day_r, mon_r, yr_r;
  logic [2:0] wd_r;
  logic       run_r, mode12_r, cap_r, view_r;
  logic [55:0] snap_r, live, rsel;

  function automatic logic [7:0] inc_bcd(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  function automatic logic [6:0] b2n(input logic [7:0] v);
    return {3'b0, v[7:4]} * 7'd10 + {3'b0, v[3:0]};
  endfunction

  function automatic logic [7:0] n2b(input logic [6:0] n);
    logic [6:0] t, u;
    t = n / 7'd10;
    u = n % 7'd10;
    return {t[3:0], u[3:0]};
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] m, input logic [7:0] y);
    logic [6:0] yn;
    yn = b2n(y);
    case (m)
      8'h02: return (yn[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction

  function automatic logic [7:0] to12(input logic [7:0] h);
    logic [6:0] n;
    n = b2n(h);
    if (n == 7'd0) return 8'h12;
    if (n < 7'd12) return n2b(n);
    if (n == 7'd12) return 8'h92;
    return n2b(n - 7'd12) | 8'h80;
  endfunction

  function automatic logic [7:0] to24(input logic [7:0] d);
    logic [6:0] n;
    n = b2n({1'b0, d[6:0]});
    if (n == 7'd12) return d[7] ? 8'h12 : 8'h00;
    return d[7] ? n2b(n + 7'd12) : n2b(n);
  endfunction

  wire       step    = run_r & tick_1hz;
  wire       time_wr = bus_we & ~run_r & (bus_addr < NFIELD);
  wire       ctrl_wr = bus_we & (bus_addr == CTRL_ADDR);
  wire [2:0] idx     = bus_addr[2:0];

  wire c_sec = sec_r == 8'h59;
  wire c_min = c_sec & (min_r == 8'h59);
  wire c_hr  = c_min & (hr_r == 8'h23);
  wire c_day = c_hr & (day_r == month_len(mon_r, yr_r));
  wire c_mon = c_day & (mon_r == 8'h12);

  assign live = {5'b0, wd_r, yr_r, mon_r, day_r, hr_r, min_r, sec_r};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_r <= 8'h00; min_r <= 8'h00; hr_r <= 8'h00;
      day_r <= 8'h01; mon_r <= 8'h01; yr_r <= 8'h00; wd_r <= 3'd0;
      run_r <= 1'b0; mode12_r <= 1'b0; cap_r <= 1'b0; view_r <= 1'b0;
      snap_r <= '0;
    end else begin
      if (step) begin
        sec_r <= c_sec ? 8'h00 : inc_bcd(sec_r);
        if (c_sec) min_r <= c_min ? 8'h00 : inc_bcd(min_r);
        if (c_min) hr_r <= c_hr ? 8'h00 : inc_bcd(hr_r);
        if (c_hr) begin
          day_r <= c_day ? 8'h01 : inc_bcd(day_r);
          wd_r  <= (wd_r == 3'd6) ? 3'd0 : wd_r + 3'd1;
        end
        if (c_day) mon_r <= c_mon ? 8'h01 : inc_bcd(mon_r);
        if (c_mon) yr_r <= (yr_r == 8'h99) ? 8'h00 : inc_bcd(yr_r);
      end
      if (time_wr) begin
        case (idx)
          3'd0: sec_r <= bus_wdata;
          3'd1: min_r <= bus_wdata;
          3'd2: hr_r  <= mode12_r ? to24(bus_wdata) : bus_wdata;
          3'd3: day_r <= bus_wdata;
          3'd4: mon_r <= bus_wdata;
          3'd5: yr_r  <= bus_wdata;
          3'd6: wd_r  <= bus_wdata[2:0];
          default: ;
        endcase
      end
      if (ctrl_wr) begin
        run_r    <= bus_wdata[0];
        mode12_r <= bus_wdata[3];
        cap_r    <= bus_wdata[6];
        view_r   <= bus_wdata[6];
        if (bus_wdata[6]) snap_r <= live;
      end else begin
        cap_r <= 1'b0;
      end
    end
  end

  assign rsel = view_r ? snap_r : live;

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_addr < NFIELD) begin
      case (idx)
        3'd0: bus_rdata = rsel[7:0];
        3'd1: bus_rdata = rsel[15:8];
        3'd2: bus_rdata = mode12_r ? to12(rsel[23:16]) : rsel[23:16];
        3'd3: bus_rdata = rsel[31:24];
        3'd4: bus_rdata = rsel[39:32];
        3'd5: bus_rdata = rsel[47:40];
        3'd6: bus_rdata = rsel[55:48];
        default: bus_rdata = 8'h00;
      endcase
    end else if (bus_addr == CTRL_ADDR) begin
      bus_rdata = {1'b0, cap_r, 2'b00, mode12_r, 2'b00, run_r};
    end else if (bus_addr == STAT_ADDR) begin
      bus_rdata = {6'b0, run_r, 1'b0};
    end
  end

  // R2
  sec_bcd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_r[3:0] <= 4'd9) && (sec_r <= 8'h59));

  // R2
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_r && tick_1hz && sec_r == 8'h59) |=> (sec_r == 8'h00));

  // R6
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_r && !(bus_we && bus_addr < NFIELD)) |=> ($stable(sec_r) && $stable(day_r)));

  // R9
  cap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_r && !ctrl_wr) |=> !cap_r);

  // R5
  wd_range_chk: assert property (@(posedge clk) disable iff (!rst_n) wd_r <= 3'd6);

  // R4
  mon_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_r >= 8'h01) && (mon_r <= 8'h12));
endmodule

// File: tb/bcd_rtc_bench.sv
module bcd_rtc_bench;
  localparam int AW = 5;
  localparam logic [AW-1:0] CTRL = AW'(8);
  localparam logic [AW-1:0] STAT = AW'(9);
  localparam int NV = 8;

  // {ticks, set sec..wd, expected sec..wd}
  localparam logic [119:0] VEC [NV] = '{
    {8'd3, 56'h58_00_00_01_01_00_00, 56'h01_01_00_01_01_00_00},
    {8'd1, 56'h59_59_23_31_01_24_02, 56'h00_00_00_01_02_24_03},
    {8'd1, 56'h59_59_23_28_02_24_06, 56'h00_00_00_29_02_24_00},
    {8'd1, 56'h59_59_23_28_02_23_06, 56'h00_00_00_01_03_23_00},
    {8'd1, 56'h59_59_23_30_04_10_01, 56'h00_00_00_01_05_10_02},
    {8'd1, 56'h59_59_23_31_12_99_05, 56'h00_00_00_01_01_00_06},
    {8'd2, 56'h56_34_12_15_06_21_03, 56'h58_34_12_15_06_21_03},
    {8'd1, 56'h59_59_00_29_02_00_04, 56'h00_00_01_29_02_00_04}
  };

  logic clk = 1'b0, rst_n = 1'b0, tick_1hz = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = 8'h00, bus_rdata, d;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bcd_rtc #(.AW(AW)) u_bcd_rtc (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] v);
    @(negedge clk); bus_addr = a; bus_wdata = v; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
    @(negedge clk); bus_we = 1'b0; bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic tick();
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int i = 0; i < 7; i++) begin
      rd(AW'(i), d);
      chk($sformatf("R1 field %0d", i), d, (i == 3 || i == 4) ? 8'h01 : 8'h00);
    end
    rd(CTRL, d); chk("R1 ctrl", d, 8'h00);
    rd(STAT, d); chk("R1 status", d, 8'h00);

    // vector table: R2 R3 R4 R5
    for (int v = 0; v < NV; v++) begin
      wr(CTRL, 8'h00);
      for (int i = 0; i < 7; i++) wr(AW'(i), VEC[v][56 + 8*(6-i) +: 8]);
      wr(CTRL, 8'h01);
      for (int t = 0; t < int'(VEC[v][119:112]); t++) tick();
      wr(CTRL, 8'h00);
      for (int i = 0; i < 7; i++) begin
        rd(AW'(i), d);
        chk($sformatf("R2/R3/R4/R5 vec %0d field %0d", v, i), d, VEC[v][8*(6-i) +: 8]);
      end
    end

    // R6 tick in run-setting cycle, halted tick, status
    wr(AW'(0), 8'h10);
    @(negedge clk); bus_addr = CTRL; bus_wdata = 8'h01; bus_we = 1'b1; tick_1hz = 1'b1;
    @(negedge clk); bus_we = 1'b0; tick_1hz = 1'b0;
    rd(STAT, d); chk("R6 status running", d, 8'h02);
    // R7 write while running ignored
    wr(AW'(0), 8'h30);
    wr(CTRL, 8'h00);
    rd(AW'(0), d); chk("R6/R7 sec unchanged", d, 8'h10);
    rd(STAT, d); chk("R6 status halted", d, 8'h00);
    tick();
    rd(AW'(0), d); chk("R6 halted tick", d, 8'h10);
    wr(AW'(0), 8'h00);
    rd(AW'(0), d); chk("R7 halted write", d, 8'h00);

    // R8 R9 capture
    wr(CTRL, 8'h01);
    @(negedge clk); bus_addr = CTRL; bus_wdata = 8'h41; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
    #1 chk("R9 capture flag set", bus_rdata, 8'h41);
    @(negedge clk); #1 chk("R9 capture flag cleared", bus_rdata, 8'h01);
    repeat (3) tick();
    rd(AW'(0), d); chk("R8 shadow sec", d, 8'h00);
    wr(CTRL, 8'h01);
    rd(AW'(0), d); chk("R8 live sec after release", d, 8'h03);
    wr(CTRL, 8'h00);

    // R10 12-hour mode
    wr(AW'(2), 8'h15);
    wr(CTRL, 8'h08);
    rd(AW'(2), d); chk("R10 15h reads", d, 8'h83);
    wr(AW'(2), 8'h92);
    wr(CTRL, 8'h00);
    rd(AW'(2), d); chk("R10 12PM write", d, 8'h12);
    wr(AW'(2), 8'h00);
    wr(CTRL, 8'h08);
    rd(AW'(2), d); chk("R10 midnight", d, 8'h12);
    wr(AW'(2), 8'h11); wr(AW'(1), 8'h59); wr(AW'(0), 8'h59);
    wr(CTRL, 8'h09);
    tick();
    wr(CTRL, 8'h08);
    rd(AW'(2), d); chk("R10 noon roll", d, 8'h92);
    rd(CTRL, d); chk("R9 ctrl readback", d, 8'h08);

    // R11 unmapped
    rd(AW'(7), d); chk("R11 addr 7", d, 8'h00);
    rd(AW'(10), d); chk("R11 addr 10", d, 8'h00);

    finish_run();
  end
endmodule